// File: doc/BRIEF.md
# Video Line Timing Generator

This block produces the frame-level control pattern for a camera-serial transmit controller. It runs in the pixel clock domain. It drives a frame sync, a line sync and a word-valid strobe, and it presents the horizontal resolution, data-type code and virtual-channel fields that the controller samples for each line. It carries no pixel data. Instead it raises a request one cycle before every valid cycle, so that an upstream pixel source can register the word it is about to present.

Every timing value is programmed on input ports:

- the sync, back-porch and front-porch lengths, horizontal in cycles and vertical in lines;
- the active pixels per line and the active lines per frame;
- the data type and the virtual channel.

The values are captured only at a frame boundary. A porch or sync value below the minimum the transmit controller accepts is raised to that minimum, so any captured set is legal. A sticky flag records that such a correction happened. The number of valid cycles per line follows from the active pixel count and the pixels carried per word by the selected data type. For the 4:2:0 types that number alternates between odd and even active lines.

Top module: `vtg_line_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero after that edge.
- R2: Each frame is made of sync lines, then back-porch lines, then active lines, then front-porch lines. `frame_sync` is low for the sync lines and high for all the other lines. Every line lasts hsync + hback + words + hfront cycles. After reset release, one start cycle precedes the first frame.
- R3: `line_sync` is low for the first hsync cycles of an active line and high for the rest of that line. It is low for the whole of every non-active line.
- R4: `word_valid` is high for a single unbroken run of `words` cycles in each active line, beginning hback cycles after `line_sync` rises. It is never high outside an active line.
- R5: words = ceil(pixels / ppw). ppw depends on the `cfg_dtype` code as follows.
  - 10 for 0x28; 8 for 0x29, 0x2A, 0x30-0x37 and any unlisted code; 6 for 0x2B; 5 for 0x2C; 4 for 0x20, 0x21, 0x22, 0x2D, 0x1A, 0x1E; 3 for 0x23; 2 for 0x24, 0x1F.
  - For 0x18 and 0x1C: 8 on odd and 4 on even active lines.
  - For 0x19 and 0x1D: 6 on odd and 2 on even active lines.
  - The first active line of a frame is odd. Non-active lines use the odd value.
- R6: `word_req` is high in exactly the cycles that immediately precede a high cycle of `word_valid`.
- R7: Values below the minimum are raised when captured. The minimum is 2 for the three horizontal values, 1 for the three vertical values, and 1 for the active pixel and active line counts.
- R8: `clamp_seen` goes high in the cycle after a capture in which any value had to be raised. Only reset clears it.
- R9: Configuration inputs are captured in the start cycle and in the last cycle of each frame. Changes at any other time have no effect until the next capture.
- R10: `line_hres` (the captured pixel count), `line_dtype` and `line_vc` show the captured values; all three are zero during the start cycle. `line_hres` and `line_dtype` hold steady while `line_sync` is high and in the cycle before it rises. `line_vc` holds steady while `frame_sync` is high and in the cycle before it rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hsync | input | 16 | Line sync length in cycles |
| cfg_hback | input | 16 | Horizontal back porch in cycles |
| cfg_hfront | input | 16 | Horizontal front porch in cycles |
| cfg_vsync | input | 16 | Frame sync length in lines |
| cfg_vback | input | 16 | Vertical back porch in lines |
| cfg_vfront | input | 16 | Vertical front porch in lines |
| cfg_pixels | input | 16 | Active pixels per line |
| cfg_lines | input | 16 | Active lines per frame |
| cfg_dtype | input | 6 | Data-type code |
| cfg_vc | input | 2 | Virtual channel |
| frame_sync | output | 1 | Frame sync |
| line_sync | output | 1 | Line sync |
| word_req | output | 1 | Word request, one cycle ahead of valid |
| word_valid | output | 1 | Data word valid |
| line_hres | output | 16 | Captured horizontal resolution |
| line_dtype | output | 6 | Captured data type |
| line_vc | output | 2 | Captured virtual channel |
| clamp_seen | output | 1 | Sticky flag: a value was raised to its minimum |

## Verification
Two functions can fall in the same cycle: capturing a new configuration, and ending the last line of a frame with the old one. Raising a value to its minimum and setting the flag land on that same edge.

The bench provokes this coincidence in two ways:
- it changes inputs mid-frame;
- it changes the data type, pixel count and virtual channel on every cycle for a long stretch, so that some changes land exactly on a capture cycle.

A behavioural reference model recomputes the line and frame layout from whatever it captured in that cycle and is compared with every output on every clock. A capture taken one cycle early or late therefore shows up as a wrong line length, a wrong field value or a wrong flag edge.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int DT_W  = 6;   // data-type code width
  localparam int PPW_W = 4;   // pixels-per-word width
  localparam int H_MIN = 2;   // horizontal porch/sync floor (cycles)
  localparam int V_MIN = 1;   // vertical porch/sync floor (lines)

  typedef enum logic [2:0] {
    PH_START,
    PH_SYNC,
    PH_BACK,
    PH_ACT,
    PH_FRONT
  } hphase_t;

  // Pixels carried by one bus word for a data type; 4:2:0 codes differ by line parity.
  function automatic logic [PPW_W-1:0] px_per_word(input logic [DT_W-1:0] code,
                                                   input logic even_line);
    logic [PPW_W-1:0] n;
    case (code)
      6'h28:                                   n = 4'd10;
      6'h2B:                                   n = 4'd6;
      6'h2C:                                   n = 4'd5;
      6'h20, 6'h21, 6'h22, 6'h2D, 6'h1A, 6'h1E: n = 4'd4;
      6'h23:                                   n = 4'd3;
      6'h24, 6'h1F:                            n = 4'd2;
      6'h18, 6'h1C:                            n = even_line ? 4'd4 : 4'd8;
      6'h19, 6'h1D:                            n = even_line ? 4'd2 : 4'd6;
      default:                                 n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/vtg_cfg_hold.sv
module vtg_cfg_hold
  import vtg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VC_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] in_hsync,
  input  logic [CNT_W-1:0] in_hback,
  input  logic [CNT_W-1:0] in_hfront,
  input  logic [CNT_W-1:0] in_vsync,
  input  logic [CNT_W-1:0] in_vback,
  input  logic [CNT_W-1:0] in_vfront,
  input  logic [CNT_W-1:0] in_pixels,
  input  logic [CNT_W-1:0] in_lines,
  input  logic [DT_W-1:0]  in_dtype,
  input  logic [VC_W-1:0]  in_vc,
  output logic [CNT_W-1:0] h_hsync,
  output logic [CNT_W-1:0] h_hback,
  output logic [CNT_W-1:0] h_hfront,
  output logic [CNT_W-1:0] h_vsync,
  output logic [CNT_W-1:0] h_vback,
  output logic [CNT_W-1:0] h_vfront,
  output logic [CNT_W-1:0] h_pixels,
  output logic [CNT_W-1:0] h_lines,
  output logic [DT_W-1:0]  h_dtype,
  output logic [VC_W-1:0]  h_vc,
  output logic             clamp_seen
);

  localparam int NV = 8;   // numeric fields: 3 horizontal, 3 vertical, pixels, lines

  logic [CNT_W-1:0] raw  [NV];
  logic [CNT_W-1:0] held [NV];
  logic [NV-1:0]    low;

  assign raw[0] = in_hsync;
  assign raw[1] = in_hback;
  assign raw[2] = in_hfront;
  assign raw[3] = in_vsync;
  assign raw[4] = in_vback;
  assign raw[5] = in_vfront;
  assign raw[6] = in_pixels;
  assign raw[7] = in_lines;

  for (genvar g = 0; g < NV; g++) begin : g_fld
    localparam logic [CNT_W-1:0] FLOOR = (g < 3) ? CNT_W'(H_MIN) : CNT_W'(V_MIN);
    assign low[g] = raw[g] < FLOOR;
    always_ff @(posedge clk) begin
      if (rst)       held[g] <= FLOOR;
      else if (load) held[g] <= low[g] ? FLOOR : raw[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_dtype    <= '0;
      h_vc       <= '0;
      clamp_seen <= 1'b0;
    end else if (load) begin
      h_dtype <= in_dtype;
      h_vc    <= in_vc;
      if (|low) clamp_seen <= 1'b1;
    end
  end

  assign h_hsync  = held[0];
  assign h_hback  = held[1];
  assign h_hfront = held[2];
  assign h_vsync  = held[3];
  assign h_vback  = held[4];
  assign h_vfront = held[5];
  assign h_pixels = held[6];
  assign h_lines  = held[7];

  // R8: once set, the flag stays set until reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(clamp_seen) |-> clamp_seen);

endmodule

// File: rtl/vtg_hseq.sv
module vtg_hseq
  import vtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hsync_len,
  input  logic [CNT_W-1:0] hback_len,
  input  logic [CNT_W-1:0] hfront_len,
  input  logic [CNT_W-1:0] act_px,
  input  logic [PPW_W-1:0] ppw,
  output hphase_t          phase,
  output logic             eol
);

  localparam int ACC_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] ppw_ext;

  assign ppw_ext = ACC_W'(ppw);
  assign eol     = (phase == PH_FRONT) && (cnt == hfront_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_START;
      cnt   <= '0;
      acc   <= '0;
    end else begin
      case (phase)
        PH_START: begin
          phase <= PH_SYNC;
          cnt   <= '0;
        end
        PH_SYNC:
          if (cnt == hsync_len - 1'b1) begin
            phase <= PH_BACK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        PH_BACK:
          if (cnt == hback_len - 1'b1) begin
            phase <= PH_ACT;
            acc   <= ppw_ext;
          end else cnt <= cnt + 1'b1;
        PH_ACT:
          if (acc >= {1'b0, act_px}) begin
            phase <= PH_FRONT;
            cnt   <= '0;
          end else acc <= acc + ppw_ext;
        PH_FRONT:
          if (eol) begin
            phase <= PH_SYNC;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        default: phase <= PH_START;
      endcase
    end
  end

  // R7: each horizontal porch/sync phase lasts at least two cycles
  p_sync_min_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SYNC && $past(phase) != PH_SYNC) |=> (phase == PH_SYNC));
  p_back_min_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BACK && $past(phase) != PH_BACK) |=> (phase == PH_BACK));
  p_front_min_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FRONT && $past(phase) != PH_FRONT) |=> (phase == PH_FRONT));

endmodule

// File: rtl/vtg_vseq.sv
module vtg_vseq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eol,
  input  logic [CNT_W-1:0] vsync_lines,
  input  logic [CNT_W-1:0] vback_lines,
  input  logic [CNT_W-1:0] act_lines,
  input  logic [CNT_W-1:0] vfront_lines,
  output logic             in_frame,
  output logic             act_line,
  output logic             line_even,
  output logic             last_line
);

  localparam int LW = CNT_W + 2;

  logic [LW-1:0] row;
  logic [LW-1:0] act_first;
  logic [LW-1:0] act_end;
  logic [LW-1:0] total;
  logic [LW-1:0] act_off;

  assign act_first = LW'(vsync_lines) + LW'(vback_lines);
  assign act_end   = act_first + LW'(act_lines);
  assign total     = act_end + LW'(vfront_lines);
  assign act_off   = row - act_first;

  assign last_line = (row == total - 1'b1);
  assign in_frame  = (row >= LW'(vsync_lines));
  assign act_line  = (row >= act_first) && (row < act_end);
  assign line_even = act_line && act_off[0];

  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (eol) row <= last_line ? '0 : row + 1'b1;
  end

  // R2: the line index never passes the frame length captured for it
  p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
    row < total);

endmodule

// File: rtl/vtg_line_timer.sv
module vtg_line_timer
  import vtg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VC_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_hsync,
  input  logic [CNT_W-1:0] cfg_hback,
  input  logic [CNT_W-1:0] cfg_hfront,
  input  logic [CNT_W-1:0] cfg_vsync,
  input  logic [CNT_W-1:0] cfg_vback,
  input  logic [CNT_W-1:0] cfg_vfront,
  input  logic [CNT_W-1:0] cfg_pixels,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic [DT_W-1:0]  cfg_dtype,
  input  logic [VC_W-1:0]  cfg_vc,
  output logic             frame_sync,
  output logic             line_sync,
  output logic             word_req,
  output logic             word_valid,
  output logic [CNT_W-1:0] line_hres,
  output logic [DT_W-1:0]  line_dtype,
  output logic [VC_W-1:0]  line_vc,
  output logic             clamp_seen
);

  logic [CNT_W-1:0] h_hsync, h_hback, h_hfront, h_vsync, h_vback, h_vfront, h_pixels, h_lines;
  logic [DT_W-1:0]  h_dtype;
  logic [VC_W-1:0]  h_vc;
  hphase_t          phase;
  logic             eol, in_frame, act_line, line_even, last_line, load;
  logic [PPW_W-1:0] ppw;

  assign load = (phase == PH_START) || (eol && last_line);
  assign ppw  = px_per_word(h_dtype, line_even);

  vtg_cfg_hold #(.CNT_W(CNT_W), .VC_W(VC_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .in_hsync(cfg_hsync), .in_hback(cfg_hback), .in_hfront(cfg_hfront),
    .in_vsync(cfg_vsync), .in_vback(cfg_vback), .in_vfront(cfg_vfront),
    .in_pixels(cfg_pixels), .in_lines(cfg_lines), .in_dtype(cfg_dtype), .in_vc(cfg_vc),
    .h_hsync(h_hsync), .h_hback(h_hback), .h_hfront(h_hfront),
    .h_vsync(h_vsync), .h_vback(h_vback), .h_vfront(h_vfront),
    .h_pixels(h_pixels), .h_lines(h_lines), .h_dtype(h_dtype), .h_vc(h_vc),
    .clamp_seen(clamp_seen)
  );

  vtg_hseq #(.CNT_W(CNT_W)) u_h (
    .clk(clk), .rst(rst),
    .hsync_len(h_hsync), .hback_len(h_hback), .hfront_len(h_hfront),
    .act_px(h_pixels), .ppw(ppw), .phase(phase), .eol(eol)
  );

  vtg_vseq #(.CNT_W(CNT_W)) u_v (
    .clk(clk), .rst(rst), .eol(eol),
    .vsync_lines(h_vsync), .vback_lines(h_vback), .act_lines(h_lines),
    .vfront_lines(h_vfront), .in_frame(in_frame), .act_line(act_line),
    .line_even(line_even), .last_line(last_line)
  );

  // decode of the current sequencer state
  logic             d_f, d_l, d_v;
  logic [CNT_W-1:0] d_hres;
  logic [DT_W-1:0]  d_dt;
  logic [VC_W-1:0]  d_vc;

  always_comb begin
    d_f    = (phase != PH_START) && in_frame;
    d_l    = act_line && (phase == PH_BACK || phase == PH_ACT || phase == PH_FRONT);
    d_v    = act_line && (phase == PH_ACT);
    d_hres = (phase == PH_START) ? '0 : h_pixels;
    d_dt   = (phase == PH_START) ? '0 : h_dtype;
    d_vc   = (phase == PH_START) ? '0 : h_vc;
  end

  // stage 1 gives the request; stage 2 gives the aligned outputs
  logic             s1_f, s1_l;
  logic [CNT_W-1:0] s1_hres;
  logic [DT_W-1:0]  s1_dt;
  logic [VC_W-1:0]  s1_vc;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_f <= 1'b0; s1_l <= 1'b0; word_req <= 1'b0;
      s1_hres <= '0; s1_dt <= '0; s1_vc <= '0;
      frame_sync <= 1'b0; line_sync <= 1'b0; word_valid <= 1'b0;
      line_hres <= '0; line_dtype <= '0; line_vc <= '0;
    end else begin
      s1_f <= d_f; s1_l <= d_l; word_req <= d_v;
      s1_hres <= d_hres; s1_dt <= d_dt; s1_vc <= d_vc;
      frame_sync <= s1_f; line_sync <= s1_l; word_valid <= word_req;
      line_hres <= s1_hres; line_dtype <= s1_dt; line_vc <= s1_vc;
    end
  end

  // R4 checker state: a fall of valid inside a line arms the gap detector
  logic prev_v, gap_seen;
  always_ff @(posedge clk) begin
    if (rst) prev_v <= 1'b0;
    else     prev_v <= word_valid;
    if (rst || !line_sync)          gap_seen <= 1'b0;
    else if (prev_v && !word_valid) gap_seen <= 1'b1;
  end

  p_valid_in_line_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (line_sync && frame_sync));
  p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
    !(gap_seen && word_valid));
  p_line_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    line_sync |-> frame_sync);
  p_line_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(line_sync) |=> !line_sync);
  p_hres_hold_r10: assert property (@(posedge clk) disable iff (rst)
    line_sync |-> ($stable(line_hres) && $stable(line_dtype)));
  p_vc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> $stable(line_vc));

endmodule

// File: tb/sim_vtg_line_timer.sv
module sim_vtg_line_timer;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] i_hsync, i_hback, i_hfront, i_vsync, i_vback, i_vfront, i_px, i_lines;
  logic [5:0]  i_dtype;
  logic [1:0]  i_vc;
  logic        frame_sync, line_sync, word_req, word_valid, clamp_seen;
  logic [15:0] line_hres;
  logic [5:0]  line_dtype;
  logic [1:0]  line_vc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vtg_line_timer u0 (
    .clk(clk), .rst(rst),
    .cfg_hsync(i_hsync), .cfg_hback(i_hback), .cfg_hfront(i_hfront),
    .cfg_vsync(i_vsync), .cfg_vback(i_vback), .cfg_vfront(i_vfront),
    .cfg_pixels(i_px), .cfg_lines(i_lines), .cfg_dtype(i_dtype), .cfg_vc(i_vc),
    .frame_sync(frame_sync), .line_sync(line_sync), .word_req(word_req),
    .word_valid(word_valid), .line_hres(line_hres), .line_dtype(line_dtype),
    .line_vc(line_vc), .clamp_seen(clamp_seen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic set_cfg(input int hs, input int hb, input int hf, input int vs,
                         input int vb, input int vf, input int al, input int px,
                         input int dt, input int vc);
    i_hsync = 16'(hs); i_hback = 16'(hb); i_hfront = 16'(hf);
    i_vsync = 16'(vs); i_vback = 16'(vb); i_vfront = 16'(vf);
    i_lines = 16'(al); i_px = 16'(px); i_dtype = 6'(dt); i_vc = 2'(vc);
  endtask

  // pixels per word from the R5 table
  function automatic int ref_ppw(input int dt, input bit even);
    if (dt == 'h18 || dt == 'h1C) return even ? 4 : 8;
    if (dt == 'h19 || dt == 'h1D) return even ? 2 : 6;
    if (dt == 'h28) return 10;
    if (dt == 'h2B) return 6;
    if (dt == 'h2C) return 5;
    if (dt == 'h23) return 3;
    if (dt == 'h24 || dt == 'h1F) return 2;
    if (dt inside {'h20, 'h21, 'h22, 'h2D, 'h1A, 'h1E}) return 4;
    return 8;
  endfunction

  function automatic int at_least(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  // reference model: captured config and frame position (line, column)
  int m_cfg[8];
  int m_dt, m_vc, m_v, m_c;
  bit m_start, m_flag, m_live;
  int n_f, n_l, n_v, n_h, n_t, n_c;   // decode of the cycle just ended (stage 1)
  int e_f, e_l, e_v, e_h, e_t, e_c;   // decode one cycle older (outputs)

  always @(posedge clk) begin
    if (rst) begin
      m_start = 1; m_v = 0; m_c = 0; m_flag = 0; m_live = 0;
      n_f = 0; n_l = 0; n_v = 0; n_h = 0; n_t = 0; n_c = 0;
      e_f = 0; e_l = 0; e_v = 0; e_h = 0; e_t = 0; e_c = 0;
    end else begin
      int a0, w, len, tot, d_f, d_l, d_v, d_h, d_t, d_c;
      bit act, even, load;
      a0  = m_cfg[3] + m_cfg[4];
      tot = a0 + m_cfg[7] + m_cfg[5];
      act = (m_v >= a0) && (m_v < a0 + m_cfg[7]);
      even = act && ((m_v - a0) % 2 == 1);
      w   = (m_cfg[6] + ref_ppw(m_dt, even) - 1) / ref_ppw(m_dt, even);
      len = m_cfg[0] + m_cfg[1] + w + m_cfg[2];
      if (m_start) begin
        d_f = 0; d_l = 0; d_v = 0; d_h = 0; d_t = 0; d_c = 0;
      end else begin
        d_f = (m_v >= m_cfg[3]) ? 1 : 0;
        d_l = (act && m_c >= m_cfg[0]) ? 1 : 0;
        d_v = (act && m_c >= m_cfg[0] + m_cfg[1] && m_c < m_cfg[0] + m_cfg[1] + w) ? 1 : 0;
        d_h = m_cfg[6]; d_t = m_dt; d_c = m_vc;
      end
      e_f = n_f; e_l = n_l; e_v = n_v; e_h = n_h; e_t = n_t; e_c = n_c;
      n_f = d_f; n_l = d_l; n_v = d_v; n_h = d_h; n_t = d_t; n_c = d_c;
      load = m_start || (m_v == tot - 1 && m_c == len - 1);
      if (load) begin
        // R7: floors applied at capture; R8: flag on any raise
        if (i_hsync < 2 || i_hback < 2 || i_hfront < 2 || i_vsync < 1 || i_vback < 1 ||
            i_vfront < 1 || i_px < 1 || i_lines < 1) m_flag = 1;
        m_cfg[0] = at_least(int'(i_hsync), 2);
        m_cfg[1] = at_least(int'(i_hback), 2);
        m_cfg[2] = at_least(int'(i_hfront), 2);
        m_cfg[3] = at_least(int'(i_vsync), 1);
        m_cfg[4] = at_least(int'(i_vback), 1);
        m_cfg[5] = at_least(int'(i_vfront), 1);
        m_cfg[6] = at_least(int'(i_px), 1);
        m_cfg[7] = at_least(int'(i_lines), 1);
        m_dt = int'(i_dtype); m_vc = int'(i_vc);
        m_start = 0; m_v = 0; m_c = 0;
      end else begin
        m_c++;
        if (m_c == len) begin
          m_c = 0;
          m_v++;
        end
      end
      m_live = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && m_live && !done) begin
      chk("R2 R7 frame_sync", int'(frame_sync), e_f);
      chk("R3 R7 line_sync", int'(line_sync), e_l);
      chk("R4 R5 word_valid", int'(word_valid), e_v);
      chk("R6 word_req", int'(word_req), n_v);
      chk("R9 R10 line_hres", int'(line_hres), e_h);
      chk("R9 R10 line_dtype", int'(line_dtype), e_t);
      chk("R9 R10 line_vc", int'(line_vc), e_c);
      chk("R8 clamp_seen", int'(clamp_seen), int'(m_flag));
    end
  end

  initial begin
    set_cfg(3, 2, 4, 2, 1, 2, 3, 7, 'h24, 1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 frame_sync", int'(frame_sync), 0);
    chk("R1 line_sync", int'(line_sync), 0);
    chk("R1 word_req", int'(word_req), 0);
    chk("R1 word_valid", int'(word_valid), 0);
    chk("R1 line_hres", int'(line_hres), 0);
    chk("R1 line_vc", int'(line_vc), 0);
    chk("R1 clamp_seen", int'(clamp_seen), 0);
    rst = 1'b0;
    repeat (260) @(negedge clk);
    // R9: change mid-frame to a 4:2:0 type with odd/even word counts (R5)
    set_cfg(2, 2, 2, 1, 2, 1, 4, 20, 'h18, 2);
    repeat (400) @(negedge clk);
    // R7 R8: every timing value under its floor
    set_cfg(0, 1, 0, 0, 0, 0, 0, 0, 'h2B, 3);
    repeat (200) @(negedge clk);
    set_cfg(4, 3, 2, 1, 1, 2, 2, 31, 'h28, 0);
    repeat (300) @(negedge clk);
    set_cfg(2, 3, 3, 2, 1, 1, 4, 13, 'h19, 1);
    repeat (400) @(negedge clk);
    set_cfg(2, 2, 5, 1, 2, 1, 3, 17, 'h05, 2);
    repeat (300) @(negedge clk);
    // fields move every cycle so some changes hit the capture cycle (R9)
    set_cfg(2, 2, 2, 1, 1, 1, 2, 8, 'h2C, 0);
    for (int k = 0; k < 600; k++) begin
      i_vc    = 2'(k);
      i_dtype = (k % 3 == 0) ? 6'h2C : 6'h1D;
      i_px    = 16'(8 + k % 13);
      @(negedge clk);
    end
    repeat (200) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule